// File: doc/BRIEF.md
# Adaptive Illumination Step Controller

This block runs an adaptive depletion-power sequence for each pixel of a scanning microscope. A rising edge on the pixel clock starts a pixel at the first illumination step. Each step has its own dwell time and its own photon-count threshold. Photon pulses from two detector inputs are counted together over the pixel. At the end of each step the count is compared with that step's threshold. If the count meets the threshold, the block moves up one power level. If it falls short, the pixel ends early at the lowest level.

The power level is chosen by driving the address and chip-select lines of an external 4:1 analog multiplexer. Step `s` selects multiplexer level `s`. Chip-select high puts the multiplexer output into high impedance. The block drives chip-select high until the first pixel arrives after enabling. The detector pulses are forwarded unchanged for an external counter, and a fixed square-wave reference clock is divided from the system clock. When the block is disabled it holds one configured level and ignores the pixel clock. All configuration arrives on plain parallel inputs.

Top module: `adaptive_step_ctrl`

## Requirements
- R1: While reset is held with `enable_i` high, `mux_cs_o` is 1, `mux_a_o` is 0 and `ref_clk_o` is 0.
- R2: While `enable_i` is 0, `mux_cs_o` is 0 and `mux_a_o` equals `hold_level_i`. Pixel clock edges change neither output.
- R3: When enabled and no pixel has started since reset or since enabling, `mux_cs_o` is 1 (high impedance).
- R4: A rising edge on `pix_clk_i` starts step 0 (`mux_a_o`=0, `mux_cs_o`=0) at the third system clock edge after the input is sampled high. This is true even in the middle of a running sequence.
- R5: Step `s` lasts `max(D_s,1)` system clock cycles, where `D_s` is field `s` of `dwell_cfg_i` (bits `s*DWELL_W` upward). At its end the block moves to step `s+1` (`mux_a_o`=s+1) if the pixel's count is at or above threshold `T_s` (field `s` of `thr_cfg_i`, bits `s*CNT_W` upward).
- R6: If the count is below `T_s` at the end of step `s`, the output goes to level 0 with `mux_cs_o`=0 and stays there until the next pixel edge.
- R7: After the last step's dwell, the output goes to level 0 with `mux_cs_o`=0 whatever the count is.
- R8: The count is the total number of rising edges on `det1_i` and `det2_i` since the pixel edge. A pulse arriving on both inputs in the same cycle adds two. The count saturates rather than wrapping.
- R9: `det1_o` follows `det1_i` and `det2_o` follows `det2_i`.
- R10: `ref_clk_o` is a square wave with a period of `REF_PERIOD` cycles. Its level is inverted after every `REF_PERIOD/2` cycles (10 and 5 by default, which gives 10 MHz from 100 MHz).
- R11: `mux_latch_o`, the tied pair of multiplexer latch controls, is always 0.
- R12: A new pixel clears the count, so pulses from the previous pixel do not count towards the new pixel's thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | 1 runs adaptive stepping; 0 holds `hold_level_i` |
| hold_level_i | input | 2 | Level driven while disabled |
| pix_clk_i | input | 1 | Pixel clock, asynchronous |
| det1_i | input | 1 | Detector 1 photon pulses, asynchronous |
| det2_i | input | 1 | Detector 2 photon pulses, asynchronous; idle if unused |
| dwell_cfg_i | input | NUM_STEPS*DWELL_W | Per-step dwell in cycles, step 0 in the low field |
| thr_cfg_i | input | NUM_STEPS*CNT_W | Per-step photon threshold, step 0 in the low field |
| det1_o | output | 1 | Copy of `det1_i` |
| det2_o | output | 1 | Copy of `det2_i` |
| mux_a_o | output | 2 | Multiplexer address (A1,A0) = selected level |
| mux_cs_o | output | 1 | Multiplexer chip-select; 1 = output in high impedance |
| mux_latch_o | output | 1 | Tied latch controls, held 0 |
| ref_clk_o | output | 1 | Divided square-wave reference clock |

## Verification
The properties make several assumptions about the inputs. `hold_level_i` is assumed steady while the block is disabled whenever the hold property is checked. The configuration buses are assumed constant across any step whose boundary is being checked. Pixel edges are assumed to be separated by enough low cycles for the synchroniser to see each one. The stimulus follows these rules: it changes dwell and threshold values only while no decision that depends on them is pending, it holds the pixel clock low for several cycles between edges, and it places detector pulses at least three cycles before the end of the step whose decision they feed.

// File: rtl/asc_pkg.sv
// Shared definitions for the adaptive illumination step controller.
// Assumes an external 4:1 multiplexer, so levels are two bits wide.
package asc_pkg;
    localparam int LVL_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // enabled, no pixel yet: output in high impedance
        ST_RUN  = 2'd1,  // stepping through illumination levels
        ST_PARK = 2'd2   // pixel ended early or completed: lowest level
    } seq_state_t;
endpackage

// File: rtl/asc_edge_sync.sv
// Two-flop synchroniser with rising-edge detection for each bit.
// Assumes every input high or low phase lasts at least two clk cycles.
module asc_edge_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic meta_q, sync_q, last_q;

            // Resample the asynchronous bit and keep its previous value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    last_q <= 1'b0;
                end else begin
                    meta_q <= async_i[g];
                    sync_q <= meta_q;
                    last_q <= sync_q;
                end
            end

            assign rise_o[g] = sync_q & ~last_q;
        end
    endgenerate
endmodule

// File: rtl/asc_photon_counter.sv
// Saturating per-pixel photon counter. It adds up to one pulse from each
// of two detectors per cycle. A clear starts a new total that includes
// the pulses seen in the same cycle.
module asc_photon_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [1:0]       pulse_i,
    output logic [CNT_W-1:0] count_o
);
    logic [1:0]       inc;
    logic [CNT_W:0]   sum_ext;
    logic [CNT_W-1:0] count_q;

    assign inc     = {1'b0, pulse_i[0]} + {1'b0, pulse_i[1]};
    assign sum_ext = {1'b0, count_q} + (CNT_W+1)'(inc);

    // Accumulate pulses, restart on clear, hold at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (clear_i)
            count_q <= CNT_W'(inc);
        else if (sum_ext[CNT_W])
            count_q <= '1;
        else
            count_q <= sum_ext[CNT_W-1:0];
    end

    assign count_o = count_q;
endmodule

// File: rtl/asc_step_seq.sv
// Per-pixel step sequencer. A start pulse enters step 0. Each step lasts
// max(dwell,1) cycles. At the end of a step the sequencer moves up one step
// if the count meets the threshold, and otherwise parks until the next start.
// The last step always parks. Assumes 2 <= NUM_STEPS <= 4.
module asc_step_seq
    import asc_pkg::*;
#(
    parameter int NUM_STEPS = 4,
    parameter int DWELL_W   = 16,
    parameter int CNT_W     = 8,
    localparam int STEP_W   = $clog2(NUM_STEPS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable_i,
    input  logic                         start_i,
    input  logic [NUM_STEPS*DWELL_W-1:0] dwell_i,
    input  logic [NUM_STEPS*CNT_W-1:0]   thr_i,
    input  logic [CNT_W-1:0]             count_i,
    output seq_state_t                   state_o,
    output logic [STEP_W-1:0]            step_o
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    seq_state_t          state_q;
    logic [STEP_W-1:0]   step_q;
    logic [DWELL_W-1:0]  timer_q;
    logic [DWELL_W-1:0]  dwell_sel, last_tick;
    logic [CNT_W-1:0]    thr_sel;
    logic                step_done, count_ok;

    assign dwell_sel = dwell_i[int'(step_q)*DWELL_W +: DWELL_W];
    assign thr_sel   = thr_i[int'(step_q)*CNT_W +: CNT_W];
    assign last_tick = (dwell_sel == '0) ? '0 : dwell_sel - DWELL_W'(1);
    assign step_done = (timer_q >= last_tick);
    assign count_ok  = (count_i >= thr_sel);

    // Advance the step state machine and the dwell timer.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            timer_q <= '0;
        end else if (start_i) begin
            state_q <= ST_RUN;
            step_q  <= '0;
            timer_q <= '0;
        end else if (state_q == ST_RUN) begin
            if (step_done) begin
                timer_q <= '0;
                if (step_q == LAST_STEP || !count_ok)
                    state_q <= ST_PARK;
                else
                    step_q <= step_q + STEP_W'(1);
            end else begin
                timer_q <= timer_q + DWELL_W'(1);
            end
        end
    end

    assign state_o = state_q;
    assign step_o  = step_q;
endmodule

// File: rtl/asc_ref_div.sv
// Divides the system clock to a square-wave reference. The output is high
// for PERIOD/2 cycles of every PERIOD cycles. Assumes PERIOD >= 2.
module asc_ref_div #(
    parameter int PERIOD = 10,
    localparam int HALF  = PERIOD / 2,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_o
);
    logic [CW-1:0] cnt_q;
    logic          ref_q;

    // Count through one period and register the phase comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ref_q <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + CW'(1);
            ref_q <= (cnt_q < CW'(HALF));
        end
    end

    assign ref_o = ref_q;
endmodule

// File: rtl/adaptive_step_ctrl.sv
// Adaptive illumination step controller. It counts photons per pixel,
// steps the depletion power through a multiplexer and forwards the detector
// pulses. Assumes the pixel clock and detector pulses are asynchronous and
// that each high or low phase is at least two clk cycles long.
module adaptive_step_ctrl
    import asc_pkg::*;
#(
    parameter int NUM_STEPS  = 4,
    parameter int DWELL_W    = 16,
    parameter int CNT_W      = 8,
    parameter int REF_PERIOD = 10,
    localparam int STEP_W    = $clog2(NUM_STEPS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable_i,
    input  logic [LVL_W-1:0]             hold_level_i,
    input  logic                         pix_clk_i,
    input  logic                         det1_i,
    input  logic                         det2_i,
    input  logic [NUM_STEPS*DWELL_W-1:0] dwell_cfg_i,
    input  logic [NUM_STEPS*CNT_W-1:0]   thr_cfg_i,
    output logic                         det1_o,
    output logic                         det2_o,
    output logic [LVL_W-1:0]             mux_a_o,
    output logic                         mux_cs_o,
    output logic                         mux_latch_o,
    output logic                         ref_clk_o
);
    logic [2:0]        rise;
    logic              pix_rise;
    logic [CNT_W-1:0]  pix_count;
    seq_state_t        seq_state;
    logic [STEP_W-1:0] seq_step;
    logic              seq_park;

    asc_edge_sync #(.WIDTH(3)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({det2_i, det1_i, pix_clk_i}),
        .rise_o  (rise)
    );

    assign pix_rise = rise[0];

    asc_photon_counter #(.CNT_W(CNT_W)) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pix_rise),
        .pulse_i (rise[2:1]),
        .count_o (pix_count)
    );

    asc_step_seq #(
        .NUM_STEPS (NUM_STEPS),
        .DWELL_W   (DWELL_W),
        .CNT_W     (CNT_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .start_i  (pix_rise),
        .dwell_i  (dwell_cfg_i),
        .thr_i    (thr_cfg_i),
        .count_i  (pix_count),
        .state_o  (seq_state),
        .step_o   (seq_step)
    );

    asc_ref_div #(.PERIOD(REF_PERIOD)) i_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_o (ref_clk_o)
    );

    assign seq_park = (seq_state == ST_PARK);

    // Map the enable and sequencer state onto multiplexer select lines.
    always_comb begin
        if (!enable_i) begin
            mux_a_o  = hold_level_i;
            mux_cs_o = 1'b0;
        end else if (seq_state == ST_RUN) begin
            mux_a_o  = LVL_W'(seq_step);
            mux_cs_o = 1'b0;
        end else begin
            mux_a_o  = '0;
            mux_cs_o = (seq_state == ST_IDLE);
        end
    end

    assign det1_o      = det1_i;
    assign det2_o      = det2_i;
    assign mux_latch_o = 1'b0;
endmodule

// File: rtl/asc_checker.sv
// Temporal checks for adaptive_step_ctrl. They are attached by bind and
// read the top ports, the synchronised pixel edge, the park flag and the
// pixel count.
module asc_checker #(
    parameter int CNT_W      = 8,
    parameter int REF_PERIOD = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic [1:0]       hold_level_i,
    input logic [1:0]       mux_a_o,
    input logic             mux_cs_o,
    input logic             ref_clk_o,
    input logic             pix_rise,
    input logic             seq_park,
    input logic [CNT_W-1:0] pix_count
);
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && $past(!enable_i) && $stable(hold_level_i))
        |-> ($stable(mux_a_o) && !mux_cs_o)); // R2

    AST_STEP_UP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable_i) && enable_i && !mux_cs_o && $past(!mux_cs_o)
         && mux_a_o != $past(mux_a_o) && mux_a_o != 2'd0)
        |-> (mux_a_o == $past(mux_a_o) + 2'd1)); // R5

    AST_PARK_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_park) && !$past(pix_rise) && $past(enable_i) && enable_i)
        |-> (mux_a_o == 2'd0 && !mux_cs_o)); // R6

    AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_rise) |-> (pix_count >= $past(pix_count))); // R8

    AST_COUNT_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_rise) |-> ({1'b0, pix_count} <= {1'b0, $past(pix_count)} + 2)); // R8

    AST_REF_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (REF_PERIOD >= 4 && $rose(ref_clk_o)) |=> ref_clk_o); // R10
endmodule

bind adaptive_step_ctrl asc_checker #(.CNT_W(CNT_W), .REF_PERIOD(REF_PERIOD)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .hold_level_i (hold_level_i),
    .mux_a_o      (mux_a_o),
    .mux_cs_o     (mux_cs_o),
    .ref_clk_o    (ref_clk_o),
    .pix_rise     (pix_rise),
    .seq_park     (seq_park),
    .pix_count    (pix_count)
);

// File: tb/test_adaptive_step_ctrl.sv
`timescale 1ns/1ps
module test_adaptive_step_ctrl;
    localparam int NS = 4, DW = 16, CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b1;
    logic [1:0] hold_level_i = 2'd0;
    logic pix_clk_i = 1'b0, det1_i = 1'b0, det2_i = 1'b0;
    logic [NS*DW-1:0] dwell_cfg_i = '0;
    logic [NS*CW-1:0] thr_cfg_i = '0;
    logic det1_o, det2_o, mux_cs_o, mux_latch_o, ref_clk_o;
    logic [1:0] mux_a_o;

    int errors = 0, checks = 0, rel = 0;
    bit done = 0;

    always #2 clk = ~clk;

    adaptive_step_ctrl i_adaptive_step_ctrl (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .hold_level_i(hold_level_i),
        .pix_clk_i(pix_clk_i), .det1_i(det1_i), .det2_i(det2_i),
        .dwell_cfg_i(dwell_cfg_i), .thr_cfg_i(thr_cfg_i),
        .det1_o(det1_o), .det2_o(det2_o), .mux_a_o(mux_a_o), .mux_cs_o(mux_cs_o),
        .mux_latch_o(mux_latch_o), .ref_clk_o(ref_clk_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic set_cfg(int d0, int d1, int d2, int d3, int t0, int t1, int t2, int t3);
        dwell_cfg_i = {DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
        thr_cfg_i   = {CW'(t3), CW'(t2), CW'(t1), CW'(t0)};
    endtask

    task automatic go_to(int t);
        while (rel < t) begin
            @(negedge clk);
            rel++;
        end
    endtask

    task automatic start_pixel();
        @(negedge clk);
        pix_clk_i = 1'b1;
        rel = 0;
    endtask

    task automatic pulse(logic a, logic b);
        det1_i = a;
        det2_i = b;
        go_to(rel + 1);
        det1_i = 1'b0;
        det2_i = 1'b0;
    endtask

    task automatic expect_at(int t, int lvl, int cs, string req);
        go_to(t);
        check({req, " level"}, int'(mux_a_o), lvl);
        check({req, " cs"}, int'(mux_cs_o), cs);
    endtask

    task automatic quiet(int n);
        pix_clk_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 cs in reset", int'(mux_cs_o), 1);
        check("R1 level in reset", int'(mux_a_o), 0);
        check("R1 ref in reset", int'(ref_clk_o), 0);
        check("R11 latch low", int'(mux_latch_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 idle high impedance", int'(mux_cs_o), 1);
    endtask

    task automatic t_passthru();
        det1_i = 1'b1; det2_i = 1'b0; #1;
        check("R9 det1 copy", int'(det1_o), 1);
        check("R9 det2 copy", int'(det2_o), 0);
        det1_i = 1'b0; det2_i = 1'b1; #1;
        check("R9 det1 copy b", int'(det1_o), 0);
        check("R9 det2 copy b", int'(det2_o), 1);
        det2_i = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_ref();
        logic r[40];
        int highs = 0, bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            r[i] = ref_clk_o;
            highs += int'(ref_clk_o);
        end
        for (int i = 0; i < 35; i++) if (r[i] == r[i+5]) bad++;
        check("R10 high cycles in 40", highs, 20);
        check("R10 half-period flips", bad, 0);
    endtask

    task automatic t_full();
        set_cfg(5, 6, 7, 8, 0, 0, 0, 0);
        start_pixel();
        expect_at(3, 0, 0, "R4 step0 start");
        go_to(5); pix_clk_i = 1'b0;
        expect_at(7, 0, 0, "R5 step0 end");
        expect_at(8, 1, 0, "R5 step1 entry");
        expect_at(13, 1, 0, "R5 step1 end");
        expect_at(14, 2, 0, "R5 step2 entry");
        expect_at(21, 3, 0, "R5 step3 entry");
        expect_at(28, 3, 0, "R5 step3 end");
        expect_at(29, 0, 0, "R7 park after last");
        expect_at(40, 0, 0, "R7 park holds");
        quiet(4);
    endtask

    task automatic t_fail();
        set_cfg(8, 8, 8, 8, 1, 5, 0, 0);
        start_pixel();
        go_to(3); pulse(1'b1, 1'b0);
        go_to(5); pix_clk_i = 1'b0;
        expect_at(11, 1, 0, "R5 pass with one photon");
        expect_at(18, 1, 0, "R6 step1 end");
        expect_at(19, 0, 0, "R6 drop to level 0");
        expect_at(27, 0, 0, "R6 stays low");
        quiet(4);
    endtask

    task automatic t_coinc(int thr, int exp_lvl, string tag);
        set_cfg(8, 8, 8, 8, thr, 0, 0, 0);
        start_pixel();
        go_to(3); pulse(1'b1, 1'b1);
        go_to(5); pix_clk_i = 1'b0;
        expect_at(11, exp_lvl, 0, tag);
        quiet(40);
    endtask

    task automatic t_dwell0();
        set_cfg(0, 8, 8, 8, 0, 0, 0, 0);
        start_pixel();
        expect_at(3, 0, 0, "R5 zero dwell step0");
        expect_at(4, 1, 0, "R5 zero dwell one cycle");
        go_to(5); pix_clk_i = 1'b0;
        quiet(40);
    endtask

    task automatic t_restart();
        set_cfg(8, 8, 8, 8, 0, 0, 0, 0);
        start_pixel();
        go_to(3); pulse(1'b1, 1'b0);
        go_to(5); pix_clk_i = 1'b0;
        go_to(6); pulse(1'b1, 1'b0);
        expect_at(19, 2, 0, "R12 first pixel step2");
        thr_cfg_i[CW-1:0] = CW'(1);
        start_pixel();
        expect_at(2, 2, 0, "R4 old step before restart");
        expect_at(3, 0, 0, "R4 restart at step0");
        go_to(5); pix_clk_i = 1'b0;
        expect_at(11, 0, 0, "R12 count cleared");
        quiet(40);
    endtask

    task automatic t_disabled();
        enable_i = 1'b0; hold_level_i = 2'd2;
        @(negedge clk);
        check("R2 hold level", int'(mux_a_o), 2);
        check("R2 cs low", int'(mux_cs_o), 0);
        start_pixel();
        expect_at(3, 2, 0, "R2 pixel ignored");
        go_to(5); pix_clk_i = 1'b0;
        expect_at(12, 2, 0, "R2 still held");
        hold_level_i = 2'd3;
        @(negedge clk);
        check("R2 new hold level", int'(mux_a_o), 3);
        enable_i = 1'b1;
        @(negedge clk);
        check("R3 re-enabled high impedance", int'(mux_cs_o), 1);
        check("R3 re-enabled level", int'(mux_a_o), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_passthru();
        t_ref();
        t_full();
        t_fail();
        t_coinc(2, 1, "R8 coincident adds two");
        t_coinc(3, 0, "R8 coincident below three");
        t_dwell0();
        t_restart();
        t_disabled();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule